// File: doc/BRIEF.md
# Dual Reference Loss-of-Signal Detector

This block watches two reference clock inputs from the point of view of a faster system clock. Each reference is brought into the system clock domain through a synchroniser, and its rising edges restart a per-input timeout counter. If a counter reaches the timeout window before another edge arrives, that input is reported as lost. The flag drops again as soon as a new edge is seen.

One 2-bit timeout code sets the window for both inputs. Each code stands for a lowest input frequency that can still be judged as present. The window in system cycles is the system frequency divided by that minimum frequency, plus a quarter of that, plus two cycles. An input slower than the chosen code's minimum is reported as lost between its edges. The loss flags only carry meaning while the reference selector runs in one of its automatic switching modes. In the two fixed-input modes both flags are held low.

Top module: `los_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, both loss flags are 0.
- R2: An input whose rising edges arrive more often than the selected window never raises its loss flag.
- R3: With the default 200 MHz system clock parameters, code 00 selects a 252-cycle window, code 01 an 84-cycle window, code 10 a 20-cycle window and code 11 a 9-cycle window. Once an input has stopped, its flag is still 0 when the window has elapsed after the input's last rising edge. It is 1 no later than 5 cycles after that.
- R4: A raised loss flag drops to 0 within 4 system cycles of a rising edge on that input.
- R5: An input slower than the code's minimum frequency is flagged as lost between its edges. A 1 MHz input is flagged under code 01 but not under code 00. An input with a 16-cycle period is not flagged under code 01.
- R6: When the selector mode is 00 or 01 (fixed input), both loss flags are 0 regardless of the inputs. From the cycle after such a mode is applied, the flags stay 0.
- R7: Each input has its own counter and flag: activity on one input has no effect on the other input's flag.
- R8: A timeout counter saturates at its window. A stopped input keeps its flag at 1 for as long as it stays stopped, without wrapping.
- R9: Counting continues during the fixed modes. When the mode changes from fixed to automatic (10 or 11) with an input that is already stopped, that input's flag is 1 in the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refClk | input | 2 | Reference clock inputs, bit 0 and bit 1 |
| timeoutCode | input | 2 | Shared timeout window code |
| modeSel | input | 2 | Reference selector mode; bit 1 set means automatic |
| lostFlag | output | 2 | Per-input loss flag, qualified by mode |

## Verification
The inputs are run at steady rates above and below each code's minimum frequency. This shows whether the window is long enough to keep present inputs quiet and short enough to catch slow ones. A single edge followed by silence is timed against the window for all four codes, which pins the window length to within a few cycles on both sides. Separate patterns cover one input toggling while the other stays quiet, a long stall to expose counter wrap, and mode switches between fixed and automatic with stopped inputs.

// File: rtl/los_pkg.sv
`timescale 1ns/100ps
package los_pkg;
  localparam int NUM_REF = 2;

  // Strobes from the control to the datapath, one bit per reference input
  typedef struct packed {
    logic [NUM_REF-1:0] cntClr;
    logic [NUM_REF-1:0] cntHold;
  } ctrlStrb_t;

  // Window in system cycles: period ratio plus a quarter margin plus sync slack
  function automatic int calcLimit(input int sysKhz, input int minKhz, input int marginDiv);
    int base;
    base = sysKhz / minKhz;
    return base + base / marginDiv + 2;
  endfunction

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/los_datapath.sv
`timescale 1ns/100ps
module los_datapath
  import los_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REF-1:0]              refClk,
  input  ctrlStrb_t                       strb,
  output logic [NUM_REF-1:0]              edgeStb,
  output logic [NUM_REF-1:0][CNT_W-1:0]   cntVal
);
  for (genvar i = 0; i < NUM_REF; i++) begin : g_ch
    logic [2:0]       syncQ;
    logic [CNT_W-1:0] cntQ;

    // Two flops for metastability, a third to find the rising edge
    always_ff @(posedge clk) begin
      if (rst) syncQ <= '0;
      else     syncQ <= {syncQ[1:0], refClk[i]};
    end

    assign edgeStb[i] = syncQ[1] & ~syncQ[2];

    always_ff @(posedge clk) begin
      if (rst)                  cntQ <= '0;
      else if (strb.cntClr[i])  cntQ <= '0;
      else if (!strb.cntHold[i]) cntQ <= cntQ + 1'b1;
    end

    assign cntVal[i] = cntQ;
  end
endmodule

// File: rtl/los_control.sv
`timescale 1ns/100ps
module los_control
  import los_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LIM0  = 252,
  parameter int LIM1  = 84,
  parameter int LIM2  = 20,
  parameter int LIM3  = 9
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [1:0]                      timeoutCode,
  input  logic [1:0]                      modeSel,
  input  logic [NUM_REF-1:0]              edgeStb,
  input  logic [NUM_REF-1:0][CNT_W-1:0]   cntVal,
  output ctrlStrb_t                       strb,
  output logic [CNT_W-1:0]                limitVal,
  output logic [NUM_REF-1:0]              lostFlag
);
  logic [NUM_REF-1:0] hitVec;
  logic               autoMode;

  assign autoMode = modeSel[1];

  always_comb begin
    unique case (timeoutCode)
      2'b00:   limitVal = CNT_W'(LIM0);
      2'b01:   limitVal = CNT_W'(LIM1);
      2'b10:   limitVal = CNT_W'(LIM2);
      default: limitVal = CNT_W'(LIM3);
    endcase
  end

  always_comb begin
    for (int i = 0; i < NUM_REF; i++) begin
      hitVec[i] = (cntVal[i] >= limitVal);
    end
    strb.cntClr  = edgeStb;
    strb.cntHold = hitVec;
  end

  always_ff @(posedge clk) begin
    if (rst) lostFlag <= '0;
    else     lostFlag <= {NUM_REF{autoMode}} & ~edgeStb & hitVec;
  end
endmodule

// File: rtl/los_detector.sv
`timescale 1ns/100ps
module los_detector
  import los_pkg::*;
#(
  parameter int SYS_KHZ    = 200000,
  parameter int MIN_KHZ_C0 = 1000,
  parameter int MIN_KHZ_C1 = 3000,
  parameter int MIN_KHZ_C2 = 13000,
  parameter int MIN_KHZ_C3 = 32000,
  parameter int MARGIN_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] refClk,
  input  logic [1:0]         timeoutCode,
  input  logic [1:0]         modeSel,
  output logic [NUM_REF-1:0] lostFlag
);
  localparam int LIM0    = calcLimit(SYS_KHZ, MIN_KHZ_C0, MARGIN_DIV);
  localparam int LIM1    = calcLimit(SYS_KHZ, MIN_KHZ_C1, MARGIN_DIV);
  localparam int LIM2    = calcLimit(SYS_KHZ, MIN_KHZ_C2, MARGIN_DIV);
  localparam int LIM3    = calcLimit(SYS_KHZ, MIN_KHZ_C3, MARGIN_DIV);
  localparam int LIM_MAX = maxOf4(LIM0, LIM1, LIM2, LIM3);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  ctrlStrb_t                     strb;
  logic [NUM_REF-1:0]            edgeStb;
  logic [NUM_REF-1:0][CNT_W-1:0] cntVal;
  logic [CNT_W-1:0]              limitVal;

  los_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .refClk  (refClk),
    .strb    (strb),
    .edgeStb (edgeStb),
    .cntVal  (cntVal)
  );

  los_control #(
    .CNT_W (CNT_W),
    .LIM0  (LIM0),
    .LIM1  (LIM1),
    .LIM2  (LIM2),
    .LIM3  (LIM3)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .timeoutCode (timeoutCode),
    .modeSel     (modeSel),
    .edgeStb     (edgeStb),
    .cntVal      (cntVal),
    .strb        (strb),
    .limitVal    (limitVal),
    .lostFlag    (lostFlag)
  );
endmodule

// File: rtl/los_detector_chk.sv
`timescale 1ns/100ps
module los_detector_chk
  import los_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic [1:0]                      modeSel,
  input logic [NUM_REF-1:0]              lostFlag,
  input logic [NUM_REF-1:0]              edgeStb,
  input logic [NUM_REF-1:0][CNT_W-1:0]   cntVal,
  input logic [CNT_W-1:0]                limitVal
);
  p_reset_low_r1: assert property (@(posedge clk) rst |=> (lostFlag == '0));

  p_fixed_low_r6: assert property (@(posedge clk) disable iff (rst)
    !modeSel[1] |=> (lostFlag == '0));

  for (genvar i = 0; i < NUM_REF; i++) begin : g_chk
    p_clear_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
      edgeStb[i] |=> !lostFlag[i]);

    p_rise_after_timeout_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(lostFlag[i]) |-> ($past(cntVal[i]) >= $past(limitVal)));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
      (cntVal[i] != '0) |-> ((cntVal[i] == CNT_W'($past(cntVal[i]) + 1'b1)) || $stable(cntVal[i])));
  end
endmodule

bind los_detector los_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .modeSel  (modeSel),
  .lostFlag (lostFlag),
  .edgeStb  (edgeStb),
  .cntVal   (cntVal),
  .limitVal (limitVal)
);

// File: tb/sim_los_detector.sv
`timescale 1ns/100ps
module sim_los_detector;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] refClk;
  logic [1:0] timeoutCode;
  logic [1:0] modeSel;
  logic [1:0] lostFlag;

  int testCnt = 0;
  int failCnt = 0;

  // Windows taken from R3
  localparam int WIN0 = 252;
  localparam int WIN1 = 84;
  localparam int WIN2 = 20;
  localparam int WIN3 = 9;

  always #2.5 clk = ~clk;

  los_detector u0 (
    .clk         (clk),
    .rst         (rst),
    .refClk      (refClk),
    .timeoutCode (timeoutCode),
    .modeSel     (modeSel),
    .lostFlag    (lostFlag)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: lostFlag=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int winOf(input logic [1:0] code);
    case (code)
      2'b00:   return WIN0;
      2'b01:   return WIN1;
      2'b10:   return WIN2;
      default: return WIN3;
    endcase
  endfunction

  // R1
  task automatic testReset();
    rst = 1'b1; refClk = 2'b00; timeoutCode = 2'b00; modeSel = 2'b10;
    waitN(5);
    check("R1", lostFlag, 2'b00);
    rst = 1'b0;
    waitN(1);
    check("R1", lostFlag, 2'b00);
  endtask

  // R2: 1 MHz on both inputs with code 00
  task automatic testPresent();
    modeSel = 2'b10; timeoutCode = 2'b00;
    for (int k = 0; k < 12; k++) begin
      waitN(100);
      refClk = ~refClk;
      check("R2", lostFlag, 2'b00);
    end
  endtask

  // R3 and R4: single rising edge then silence, per code
  task automatic testWindow(input logic [1:0] code);
    int w;
    w = winOf(code);
    modeSel = 2'b10; timeoutCode = code;
    refClk = 2'b00;
    waitN(3);
    refClk = 2'b11;
    waitN(w);
    check("R3", lostFlag, 2'b00);
    waitN(5);
    check("R3", lostFlag, 2'b11);
    refClk = 2'b00;
    waitN(2);
    refClk = 2'b11;
    waitN(1);
    check("R4", lostFlag, 2'b11);
    waitN(3);
    check("R4", lostFlag, 2'b00);
  endtask

  // R5
  task automatic testRates();
    modeSel = 2'b11;
    timeoutCode = 2'b01;
    refClk = 2'b00; waitN(3); refClk = 2'b11;
    waitN(100); refClk = 2'b00;
    waitN(95);
    check("R5", lostFlag, 2'b11);
    timeoutCode = 2'b00;
    waitN(5); refClk = 2'b11;
    waitN(100); refClk = 2'b00;
    waitN(95);
    check("R5", lostFlag, 2'b00);
    timeoutCode = 2'b01;
    for (int k = 0; k < 20; k++) begin
      waitN(8);
      refClk = ~refClk;
    end
    check("R5", lostFlag, 2'b00);
  endtask

  // R6 and R9
  task automatic testFixed();
    timeoutCode = 2'b00;
    refClk = 2'b11;
    modeSel = 2'b00;
    waitN(1);
    check("R6", lostFlag, 2'b00);
    waitN(300);
    check("R6", lostFlag, 2'b00);
    modeSel = 2'b01;
    waitN(300);
    check("R6", lostFlag, 2'b00);
    modeSel = 2'b11;
    waitN(1);
    check("R9", lostFlag, 2'b11);
  endtask

  // R7
  task automatic testIndependent();
    modeSel = 2'b10; timeoutCode = 2'b10;
    refClk = 2'b00;
    for (int k = 0; k < 30; k++) begin
      waitN(5);
      refClk[0] = ~refClk[0];
    end
    check("R7", lostFlag, 2'b10);
    for (int k = 0; k < 30; k++) begin
      waitN(5);
      refClk[1] = ~refClk[1];
    end
    check("R7", lostFlag, 2'b01);
  endtask

  // R8
  task automatic testSaturate();
    modeSel = 2'b10; timeoutCode = 2'b11;
    refClk = 2'b11;
    for (int k = 0; k < 12; k++) begin
      waitN(50);
      check("R8", lostFlag, 2'b11);
    end
    refClk = 2'b00; waitN(2); refClk = 2'b11;
    waitN(4);
    check("R8", lostFlag, 2'b00);
  endtask

  initial begin
    testReset();
    testPresent();
    for (int c = 0; c < 4; c++) testWindow(2'(c));
    testRates();
    testFixed();
    testIndependent();
    testSaturate();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule